// File: doc/BRIEF.md
# PCI Configuration Cycle Address Generator

This block turns a host request for PCI configuration space into the address, byte enables, write data and cycle type that a downstream PCI master engine needs. A request names a bus, a device slot, a function, a register offset, an access size (byte, word or longword) and a direction. For bus zero the block forms a Type 0 address in which the device is picked by a one-hot select line. For any other bus it forms a Type 1 address, and it raises a separate mode bit around that single access so the downstream engine issues a Type 1 cycle.

The host side uses a valid/ready handshake. A one-cycle `done` pulse ends each request, and only one request is in flight at a time. The downstream side holds `cycValid` and the cycle fields steady until the engine returns `cycAck`, along with either read data or a no-response indication (master abort). Some requests are settled without issuing any cycle: a misaligned access, and a bus-zero slot beyond the supported device count. For reads that get no response, the block returns all ones in the requested width.

Top module: `pcicfg_xlate`

## Requirements
- R1: For bus zero, `cycAddr` is (1 << (slot+11)) | function<<8 | register. Exactly one of bits 22..11 is set, and the bits above 22 are zero.
- R2: For a non-zero bus, `cycAddr` is bus<<16 | slot<<11 | function<<8 | register.
- R3: For a non-zero bus, `type1Mode` rises one clock before `cycValid` and stays high until the acknowledge. It is low again by the `done` pulse. It never rises for bus zero and is low whenever `reqReady` is high.
- R4: Size codes are 0 byte, 1 word, 2 longword. For a successful read, `rdData` is `cycRdata` shifted right by register[1:0]*8 and masked to the access width. For a write, `rdData` is zero.
- R5: When the target does not respond (`cycNoResp` with `cycAck`), `noResp` is set. A read then returns all ones in its width (0xFF, 0xFFFF or 0xFFFFFFFF). A write reports `noResp` with `rdData` zero.
- R6: On bus zero, a request for slot 12 or above issues no cycle. It completes with `noResp` set, and a read returns all ones in its width.
- R7: `cycByteEn` is 0001<<off for byte, 0011<<off for word and 1111 for longword, where off is register[1:0]. `cycWdata` is the write data shifted left by off*8.
- R8: A word access with register[0]=1, a longword access with register[1:0]≠0, or size code 3 issues no cycle and completes with `alignErr` set and `rdData` zero. This check takes priority over the slot check.
- R9: `reqReady` is high only when idle. A request is accepted on a clock where `reqValid` and `reqReady` are both high. `done` is a one-clock pulse, and the results stay unchanged after it until the next acceptance.
- R10: Once `cycValid` rises, it and `cycAddr` hold steady until the clock on which `cycAck` is sampled high.
- R11: After reset `reqReady` is 1, and `cycValid`, `done`, `type1Mode`, `noResp`, `alignErr` and `rdData` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle, request can be taken |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqBus | input | 8 | Target bus number |
| reqSlot | input | 5 | Target device slot |
| reqFunc | input | 3 | Target function |
| reqReg | input | 8 | Register byte offset |
| reqSize | input | 2 | 0 byte, 1 word, 2 longword |
| reqWdata | input | 32 | Write data, right-aligned |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | 32 | Read result, right-aligned |
| noResp | output | 1 | Target absent or slot out of range |
| alignErr | output | 1 | Misaligned or illegal size |
| cycValid | output | 1 | Configuration cycle request |
| cycAck | input | 1 | Cycle finished |
| cycNoResp | input | 1 | Cycle ended with no target response |
| cycWrite | output | 1 | Cycle direction |
| type1Mode | output | 1 | Type 1 cycle select bit |
| cycAddr | output | 32 | Configuration address |
| cycByteEn | output | 4 | Active-high byte enables |
| cycWdata | output | 32 | Lane-placed write data |
| cycRdata | input | 32 | Raw read data from the cycle |

## Verification
If the latched request or the lane offset is wrong, the fault shows up in `cycAddr` and `cycByteEn` on the very first clock that `cycValid` is high. If the sequencing state is wrong, the mode bit is seen high while idle, high during a bus-zero cycle, or low on the clock before a Type 1 cycle, so it is visible within one cycle. A wrong result path appears in `rdData`, `noResp` or `alignErr` on the `done` pulse. A misbehaving no-cycle path shows up either as a cycle that should not have been issued or as a missing all-ones value.

// File: rtl/pcicfg_pkg.sv
package pcicfg_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_BAD  = 2'd3
  } accSize_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_ISSUE,
    ST_RESTORE,
    ST_DONE
  } ctlState_e;

  // control -> datapath
  typedef struct packed {
    logic load;
    logic capture;
  } ctlStrobe_t;

  // datapath -> control, decoded from the incoming request
  typedef struct packed {
    logic farBus;
    logic slotMiss;
    logic misalign;
  } reqFlags_t;

endpackage

// File: rtl/pcicfg_dpath.sv
module pcicfg_dpath
  import pcicfg_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int SLOT_W    = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_SLOTS = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctlStrobe_t        strobe,
  input  logic              reqWrite,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [SLOT_W-1:0] reqSlot,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [REG_W-1:0]  reqReg,
  input  logic [1:0]        reqSize,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              cycNoResp,
  input  logic [DATA_W-1:0] cycRdata,
  output reqFlags_t         flags,
  output logic              cycWrite,
  output logic [ADDR_W-1:0] cycAddr,
  output logic [DATA_W/8-1:0] cycByteEn,
  output logic [DATA_W-1:0] cycWdata,
  output logic [DATA_W-1:0] rdData,
  output logic              noResp,
  output logic              alignErr
);

  localparam int LANES    = DATA_W / 8;
  localparam int OFF_W    = $clog2(LANES);
  localparam int FUNC_LSB = REG_W;
  localparam int SLOT_LSB = FUNC_LSB + FUNC_W;
  localparam int BUS_LSB  = SLOT_LSB + SLOT_W;

  function automatic logic [DATA_W-1:0] widthMask(input logic [1:0] sz);
    case (sz)
      SZ_BYTE: return DATA_W'(8'hFF);
      SZ_WORD: return DATA_W'(16'hFFFF);
      default: return '1;
    endcase
  endfunction

  function automatic logic isMisaligned(input logic [1:0] sz, input logic [OFF_W-1:0] off);
    case (sz)
      SZ_BYTE: return 1'b0;
      SZ_WORD: return off[0];
      SZ_LONG: return off != '0;
      default: return 1'b1;
    endcase
  endfunction

  // request decode on the live inputs, used at acceptance
  logic [OFF_W-1:0] offIn;
  assign offIn          = reqReg[OFF_W-1:0];
  assign flags.misalign = isMisaligned(reqSize, offIn);
  assign flags.farBus   = reqBus != '0;
  assign flags.slotMiss = (reqBus == '0) && (int'(reqSlot) >= MAX_SLOTS);

  // latched request
  logic [BUS_W-1:0]  busQ;
  logic [SLOT_W-1:0] slotQ;
  logic [FUNC_W-1:0] funcQ;
  logic [REG_W-1:0]  regQ;
  logic [1:0]        sizeQ;
  logic [DATA_W-1:0] wdataQ;
  logic              writeQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busQ   <= '0;
      slotQ  <= '0;
      funcQ  <= '0;
      regQ   <= '0;
      sizeQ  <= '0;
      wdataQ <= '0;
      writeQ <= 1'b0;
    end else if (strobe.load) begin
      busQ   <= reqBus;
      slotQ  <= reqSlot;
      funcQ  <= reqFunc;
      regQ   <= reqReg;
      sizeQ  <= reqSize;
      wdataQ <= reqWdata;
      writeQ <= reqWrite;
    end
  end

  logic [OFF_W-1:0] offQ;
  assign offQ     = regQ[OFF_W-1:0];
  assign cycWrite = writeQ;

  // address formation
  logic [ADDR_W-1:0] lowPart;
  assign lowPart = (ADDR_W'(funcQ) << FUNC_LSB) | ADDR_W'(regQ);

  always_comb begin
    if (busQ != '0)
      cycAddr = (ADDR_W'(busQ) << BUS_LSB) | (ADDR_W'(slotQ) << SLOT_LSB) | lowPart;
    else
      cycAddr = (ADDR_W'(1) << (SLOT_LSB + int'(slotQ))) | lowPart;
  end

  // byte lanes
  always_comb begin
    case (sizeQ)
      SZ_BYTE: cycByteEn = LANES'(1) << offQ;
      SZ_WORD: cycByteEn = LANES'(3) << offQ;
      SZ_LONG: cycByteEn = '1;
      default: cycByteEn = '0;
    endcase
  end
  assign cycWdata = wdataQ << {offQ, 3'b000};

  // results
  logic [DATA_W-1:0] readAligned;
  assign readAligned = (cycRdata >> {offQ, 3'b000}) & widthMask(sizeQ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdData   <= '0;
      noResp   <= 1'b0;
      alignErr <= 1'b0;
    end else if (strobe.load) begin
      alignErr <= flags.misalign;
      noResp   <= !flags.misalign && flags.slotMiss;
      rdData   <= (!flags.misalign && flags.slotMiss && !reqWrite) ? widthMask(reqSize) : '0;
    end else if (strobe.capture) begin
      noResp <= cycNoResp;
      if (writeQ)
        rdData <= '0;
      else if (cycNoResp)
        rdData <= widthMask(sizeQ);
      else
        rdData <= readAligned;
    end
  end

endmodule

// File: rtl/pcicfg_ctrl.sv
module pcicfg_ctrl
  import pcicfg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reqValid,
  input  reqFlags_t  flags,
  input  logic       cycAck,
  output logic       reqReady,
  output logic       cycValid,
  output logic       type1Mode,
  output logic       done,
  output ctlStrobe_t strobe
);

  ctlState_e state, stateNext;
  logic      modeQ;
  logic      skipCycle;

  assign skipCycle = flags.misalign || flags.slotMiss;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.load = 1'b1;
          if (skipCycle)         stateNext = ST_DONE;
          else if (flags.farBus) stateNext = ST_SETUP;
          else                   stateNext = ST_ISSUE;
        end
      end
      ST_SETUP:   stateNext = ST_ISSUE;
      ST_ISSUE: begin
        if (cycAck) begin
          strobe.capture = 1'b1;
          stateNext      = modeQ ? ST_RESTORE : ST_DONE;
        end
      end
      ST_RESTORE: stateNext = ST_DONE;
      ST_DONE:    stateNext = ST_IDLE;
      default:    stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      modeQ <= 1'b0;
    end else begin
      state <= stateNext;
      if (state == ST_IDLE && reqValid && !skipCycle && flags.farBus)
        modeQ <= 1'b1;
      else if (state == ST_ISSUE && cycAck)
        modeQ <= 1'b0;
    end
  end

  assign reqReady  = state == ST_IDLE;
  assign cycValid  = state == ST_ISSUE;
  assign done      = state == ST_DONE;
  assign type1Mode = modeQ;

endmodule

// File: rtl/pcicfg_xlate.sv
module pcicfg_xlate
  import pcicfg_pkg::*;
#(
  parameter int BUS_W     = 8,
  parameter int SLOT_W    = 5,
  parameter int FUNC_W    = 3,
  parameter int REG_W     = 8,
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 32,
  parameter int MAX_SLOTS = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reqValid,
  output logic                reqReady,
  input  logic                reqWrite,
  input  logic [BUS_W-1:0]    reqBus,
  input  logic [SLOT_W-1:0]   reqSlot,
  input  logic [FUNC_W-1:0]   reqFunc,
  input  logic [REG_W-1:0]    reqReg,
  input  logic [1:0]          reqSize,
  input  logic [DATA_W-1:0]   reqWdata,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic                noResp,
  output logic                alignErr,
  output logic                cycValid,
  input  logic                cycAck,
  input  logic                cycNoResp,
  output logic                cycWrite,
  output logic                type1Mode,
  output logic [ADDR_W-1:0]   cycAddr,
  output logic [DATA_W/8-1:0] cycByteEn,
  output logic [DATA_W-1:0]   cycWdata,
  input  logic [DATA_W-1:0]   cycRdata
);

  ctlStrobe_t strobe;
  reqFlags_t  flags;

  pcicfg_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .flags     (flags),
    .cycAck    (cycAck),
    .reqReady  (reqReady),
    .cycValid  (cycValid),
    .type1Mode (type1Mode),
    .done      (done),
    .strobe    (strobe)
  );

  pcicfg_dpath #(
    .BUS_W(BUS_W), .SLOT_W(SLOT_W), .FUNC_W(FUNC_W), .REG_W(REG_W),
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .MAX_SLOTS(MAX_SLOTS)
  ) u_dpath (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe    (strobe),
    .reqWrite  (reqWrite),
    .reqBus    (reqBus),
    .reqSlot   (reqSlot),
    .reqFunc   (reqFunc),
    .reqReg    (reqReg),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .cycNoResp (cycNoResp),
    .cycRdata  (cycRdata),
    .flags     (flags),
    .cycWrite  (cycWrite),
    .cycAddr   (cycAddr),
    .cycByteEn (cycByteEn),
    .cycWdata  (cycWdata),
    .rdData    (rdData),
    .noResp    (noResp),
    .alignErr  (alignErr)
  );

endmodule

// File: rtl/pcicfg_xlate_chk.sv
module pcicfg_xlate_chk #(
  parameter int ADDR_W    = 32,
  parameter int LANES     = 4,
  parameter int SEL_LSB   = 11,
  parameter int MAX_SLOTS = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reqValid,
  input logic              reqReady,
  input logic              done,
  input logic              cycValid,
  input logic              cycAck,
  input logic              type1Mode,
  input logic [ADDR_W-1:0] cycAddr,
  input logic [LANES-1:0]  cycByteEn
);

  localparam int SEL_TOP = SEL_LSB + MAX_SLOTS;

  // R1: a bus-zero cycle carries exactly one device select, nothing above it
  assert_onehot_sel_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (cycValid && !type1Mode) |->
      ($countones(cycAddr[SEL_TOP-1:SEL_LSB]) == 1 && cycAddr[ADDR_W-1:SEL_TOP] == '0));

  // R3: mode bit low while idle
  assert_mode_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    reqReady |-> !type1Mode);

  // R3: a Type 1 cycle is preceded by the mode bit
  assert_mode_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cycValid) && type1Mode) |-> $past(type1Mode));

  // R3: mode bit released by the completion pulse
  assert_mode_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !type1Mode);

  // R7: a cycle always enables at least one lane
  assert_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cycValid |-> cycByteEn != '0);

  // R9: single outstanding request, single-cycle done
  assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reqValid && reqReady) |=> !reqReady);
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10: cycle request held until acknowledged
  assert_cyc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cycValid && !cycAck) |=> (cycValid && $stable(cycAddr) && $stable(type1Mode)));

endmodule

bind pcicfg_xlate pcicfg_xlate_chk #(
  .ADDR_W(ADDR_W), .LANES(DATA_W/8), .SEL_LSB(REG_W + FUNC_W), .MAX_SLOTS(MAX_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady), .done(done),
  .cycValid(cycValid), .cycAck(cycAck), .type1Mode(type1Mode), .cycAddr(cycAddr),
  .cycByteEn(cycByteEn)
);

// File: tb/sim_pcicfg_xlate.sv
`timescale 1ns/1ps
module sim_pcicfg_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqSlot = '0;
  logic [2:0]  reqFunc = '0;
  logic [7:0]  reqReg = '0;
  logic [1:0]  reqSize = '0;
  logic [31:0] reqWdata = '0;
  logic        cycAck = 1'b0;
  logic        cycNoResp = 1'b0;
  logic [31:0] cycRdata = '0;
  logic        reqReady, done, noResp, alignErr, cycValid, cycWrite, type1Mode;
  logic [31:0] rdData, cycAddr, cycWdata;
  logic [3:0]  cycByteEn;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  pcicfg_xlate u0 (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqBus(reqBus), .reqSlot(reqSlot), .reqFunc(reqFunc),
    .reqReg(reqReg), .reqSize(reqSize), .reqWdata(reqWdata), .done(done),
    .rdData(rdData), .noResp(noResp), .alignErr(alignErr), .cycValid(cycValid),
    .cycAck(cycAck), .cycNoResp(cycNoResp), .cycWrite(cycWrite), .type1Mode(type1Mode),
    .cycAddr(cycAddr), .cycByteEn(cycByteEn), .cycWdata(cycWdata), .cycRdata(cycRdata)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mkAddr(input logic [7:0] b, input logic [4:0] s,
                                         input logic [2:0] f, input logic [7:0] r);
    if (b != 0) return {8'h0, b, s, f, r};
    return (32'd1 << (int'(s) + 11)) | {21'h0, f, r};
  endfunction

  function automatic logic [31:0] mask(input logic [1:0] sz);
    return sz == 2'd0 ? 32'hFF : sz == 2'd1 ? 32'hFFFF : 32'hFFFF_FFFF;
  endfunction

  function automatic logic [3:0] mkBe(input logic [1:0] sz, input logic [1:0] off);
    return sz == 2'd0 ? 4'b0001 << off : sz == 2'd1 ? 4'b0011 << off : 4'b1111;
  endfunction

  function automatic logic [31:0] tgtData(input logic [31:0] a);
    return (a * 32'h9E37_79B1) ^ 32'h5A5A_1234;
  endfunction

  task automatic runReq(input logic [7:0] b, input logic [4:0] s, input logic [2:0] f,
                        input logic [7:0] r, input logic [1:0] sz, input bit wr,
                        input logic [31:0] wd, input bit present, input int waitN);
    bit mis, miss, expCyc, expT1, expNr;
    logic [31:0] expRd, firstAddr, heldRd;
    int seen = 0;
    int issued = 0;
    bit prevMode = 0;
    bit gotDone = 0;
    mis    = (sz == 2'd3) || (sz == 2'd1 && r[0]) || (sz == 2'd2 && r[1:0] != 0);
    miss   = !mis && b == 0 && s >= 12;
    expCyc = !mis && !miss;
    expT1  = b != 0;
    expNr  = miss || (expCyc && !present);
    if (wr || mis) expRd = 0;
    else if (expNr) expRd = mask(sz);
    else expRd = (tgtData(mkAddr(b, s, f, r)) >> (8 * int'(r[1:0]))) & mask(sz);
    firstAddr = 0;

    @(negedge clk);
    reqValid = 1; reqBus = b; reqSlot = s; reqFunc = f; reqReg = r;
    reqSize = sz; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 0;
    for (int i = 0; i < 40; i++) begin
      if (done) begin gotDone = 1; break; end
      if (cycValid) begin
        if (seen == 0) begin
          issued++;
          firstAddr = cycAddr;
          check(cycAddr == mkAddr(b, s, f, r), expT1 ? "R2 type1 address" : "R1 type0 address",
                cycAddr, mkAddr(b, s, f, r));
          check(type1Mode == expT1, "R3 mode during cycle", {31'h0, type1Mode}, {31'h0, expT1});
          if (expT1) check(prevMode, "R3 mode set before cycle", {31'h0, prevMode}, 32'h1);
          check(cycByteEn == mkBe(sz, r[1:0]), "R7 byte enables", {28'h0, cycByteEn},
                {28'h0, mkBe(sz, r[1:0])});
          if (wr) check(cycWdata == (wd << (8 * int'(r[1:0]))), "R7 write lanes", cycWdata,
                        wd << (8 * int'(r[1:0])));
        end else begin
          check(cycAddr == firstAddr, "R10 address held", cycAddr, firstAddr);
        end
        if (seen >= waitN) begin
          cycAck = 1; cycNoResp = !present;
          cycRdata = tgtData(cycAddr);
        end
        seen++;
      end else begin
        cycAck = 0; cycNoResp = 0;
      end
      prevMode = type1Mode;
      @(negedge clk);
    end
    cycAck = 0; cycNoResp = 0;
    check(gotDone, "R9 done reached", {31'h0, gotDone}, 32'h1);
    check(issued == int'(expCyc), mis ? "R8 no cycle" : "R6 cycle count",
          issued, int'(expCyc));
    check(rdData == expRd, expNr ? "R5 all-ones/no-response data" : "R4 read data",
          rdData, expRd);
    check(noResp == expNr, miss ? "R6 slot miss flag" : "R5 no-response flag",
          {31'h0, noResp}, {31'h0, expNr});
    check(alignErr == mis, "R8 alignment flag", {31'h0, alignErr}, {31'h0, mis});
    check(!type1Mode, "R3 mode restored", {31'h0, type1Mode}, 32'h0);
    heldRd = rdData;
    @(negedge clk);
    check(!done && reqReady && rdData == heldRd, "R9 done pulse and hold",
          {29'h0, done, reqReady, rdData == heldRd}, 32'h3);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(reqReady && !cycValid && !done && !type1Mode && !noResp && !alignErr && rdData == 0,
          "R11 reset state", {26'h0, reqReady, cycValid, done, type1Mode, noResp, alignErr}, 32'h20);

    // directed corners
    runReq(8'd0, 5'd0, 3'd0, 8'h00, 2'd2, 0, 0, 1, 0);          // R1 longword
    runReq(8'd0, 5'd11, 3'd7, 8'hFF, 2'd0, 0, 0, 1, 2);         // R1 top slot, byte off 3
    runReq(8'd0, 5'd12, 3'd0, 8'h10, 2'd0, 0, 0, 1, 0);         // R6 first missing slot
    runReq(8'd0, 5'd31, 3'd1, 8'h04, 2'd2, 1, 32'hDEAD_BEEF, 1, 0); // R6 write miss
    runReq(8'd5, 5'd3, 3'd2, 8'h42, 2'd1, 0, 0, 1, 1);          // R2 R3 word off 2
    runReq(8'hFF, 5'd31, 3'd7, 8'hFC, 2'd2, 1, 32'h1234_5678, 1, 0); // R2 max fields
    runReq(8'd0, 5'd4, 3'd0, 8'h02, 2'd1, 0, 0, 0, 0);          // R5 absent word read
    runReq(8'd9, 5'd4, 3'd0, 8'h01, 2'd0, 0, 0, 0, 0);          // R5 absent type1 byte
    runReq(8'd0, 5'd4, 3'd0, 8'h08, 2'd2, 1, 32'hCAFE_F00D, 0, 1); // R5 absent write
    runReq(8'd0, 5'd1, 3'd0, 8'h01, 2'd1, 0, 0, 1, 0);          // R8 word odd
    runReq(8'd0, 5'd20, 3'd0, 8'h02, 2'd2, 0, 0, 1, 0);         // R8 beats slot miss
    runReq(8'd3, 5'd1, 3'd0, 8'h00, 2'd3, 0, 0, 1, 0);          // R8 bad size code
    runReq(8'd0, 5'd2, 3'd3, 8'h13, 2'd0, 1, 32'h0000_00A5, 1, 0); // R7 byte write lane 3

    for (int n = 0; n < 400; n++) begin
      logic [7:0] b;
      logic [1:0] sz;
      b  = ($urandom % 2) ? 8'($urandom) : 8'd0;
      sz = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      runReq(b, 5'($urandom % 16), 3'($urandom), 8'($urandom), sz, 1'($urandom),
             $urandom, ($urandom % 5) != 0, int'($urandom % 3));
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule